// File: doc/BRIEF.md
# Self-Replaying Byte Stream Transmitter

This block sends one message at a time onto a byte-wide network link and keeps resending it until the network accepts it. A host first loads the whole message into a local buffer, one byte per accepted write. It then pulses a start strobe. From that point the block runs on its own. It streams the stored bytes in write order, then waits for a delivery verdict from the network.

When the verdict is a failure, the block resends the whole message from its first byte, with no help from the host. There is no limit on the number of attempts. When the verdict is success, the block empties its buffer, drops busy and raises a one-cycle done pulse. The host may then load the next message.

Both data paths use valid/ready handshakes. A host byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. A link byte moves on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the block holds `tx_data` steady and keeps `tx_valid` high, so the link can stall it at any point. The start strobe, busy, done and the verdict pins are plain level or pulse signals.

Top module: `retry_tx`

## Requirements
- R1: After reset, `busy`, `tx_valid` and `done` are low and `wr_ready` is high.
- R2: A host byte is stored on each edge with `wr_valid && wr_ready`, appended after the bytes already held. `wr_ready` is low while `busy` is high or while the buffer holds DEPTH bytes. The stored length does not change while a message is in flight.
- R3: A start strobe taken while idle with at least one byte stored raises `busy` and `tx_valid` in the next cycle, beginning at stored byte 0.
- R4: A start strobe with an empty buffer, or while `busy` is high, has no effect.
- R5: Bytes leave in the order they were written, one per edge with `tx_valid && tx_ready`. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` stay unchanged.
- R6: After the last byte is taken, `tx_valid` goes low and the block waits for a verdict. `net_valid` is heeded only during this wait; a verdict given while bytes are still being sent is ignored.
- R7: The verdict is read from `net_ok` while `net_valid` is high; `net_ok` = 0 means failure. A failure verdict makes `tx_valid` high again in the next cycle, restarting at stored byte 0. This repeats for any number of failures.
- R8: A success verdict (`net_ok` = 1) gives `done` high for exactly one cycle in the next cycle. In that same cycle `busy` is low and the buffer is empty, so `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host byte offered |
| wr_ready | output | 1 | Buffer can take a host byte |
| wr_data | input | 8 | Host byte |
| start | input | 1 | Launch strobe |
| busy | output | 1 | Message in flight, from launch until success |
| done | output | 1 | One-cycle pulse on success |
| tx_valid | output | 1 | Link byte offered |
| tx_ready | input | 1 | Link takes the byte |
| tx_data | output | 8 | Link byte |
| net_valid | input | 1 | Delivery verdict present |
| net_ok | input | 1 | Verdict: 1 success, 0 failure |

## Verification
The hardest case to reach from the ports is a replay that happens while the link is also applying back-pressure. In that case the read position has to jump back to byte 0 even though a stalled byte may have been waiting the cycle before. A second hard case is a verdict that arrives while bytes are still being sent, which must not end or restart the message.

The stimulus reaches these cases by giving each message a planned number of failure verdicts. It throttles `tx_ready` randomly on every attempt. On some messages it also drives random verdicts and stray start strobes during sending, and stray host writes against a full buffer. The bench then checks every byte of every attempt against its own copy of the message.

// File: rtl/retry_tx_pkg.sv
package retry_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/retry_tx_buf.sv
module retry_tx_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          clear,
  input  logic [AW-1:0] rd_ptr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] len,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;

  assign wr_ptr  = len[AW-1:0];
  assign full    = (len == CW'(DEPTH));
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     len <= '0;
    else if (clear) len <= '0;
    else if (wr_en) len <= len + CW'(1);
  end

  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    len <= CW'(DEPTH)); // R2
endmodule

// File: rtl/retry_tx_seq.sv
module retry_tx_seq
  import retry_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  input  logic          tx_ready,
  input  logic          net_valid,
  input  logic          net_ok,
  output logic          tx_valid,
  output logic [AW-1:0] rd_ptr,
  output logic          busy,
  output logic          done,
  output logic          clear
);
  tx_state_e state;
  logic      launch;
  logic      last;

  assign launch   = start && (len != '0);
  assign last     = (CW'(rd_ptr) == len - CW'(1));
  assign tx_valid = (state == ST_SEND);
  assign busy     = (state != ST_IDLE);
  assign clear    = (state == ST_WAIT) && net_valid && net_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rd_ptr <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (launch) begin
          state  <= ST_SEND;
          rd_ptr <= '0;
        end
        ST_SEND: if (tx_ready) begin
          if (last) state  <= ST_WAIT;
          else      rd_ptr <= rd_ptr + AW'(1);
        end
        ST_WAIT: if (net_valid) begin
          if (net_ok) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state  <= ST_SEND;
            rd_ptr <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_FAIL_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && net_valid && !net_ok) |=> (tx_valid && rd_ptr == '0)); // R7
  AST_SEND_IGNORES_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && !tx_ready) |=> (state == ST_SEND)); // R6
endmodule

// File: rtl/retry_tx.sv
module retry_tx #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          net_valid,
  input  logic          net_ok
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          full;
  logic          wr_en;
  logic          clear;
  logic [CW-1:0] len;
  logic [AW-1:0] rd_ptr;

  assign wr_ready = !busy && !full;
  assign wr_en    = wr_valid && wr_ready;

  retry_tx_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clear(clear), .rd_ptr(rd_ptr), .rd_data(tx_data), .len(len), .full(full)
  );

  retry_tx_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .tx_ready(tx_ready), .net_valid(net_valid), .net_ok(net_ok),
    .tx_valid(tx_valid), .rd_ptr(rd_ptr), .busy(busy), .done(done), .clear(clear)
  );

  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(len)); // R2
  AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && len == '0 && !wr_valid) |=> !busy); // R4
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && wr_ready)); // R8
endmodule

// File: tb/retry_tx_test.sv
`timescale 1ns/1ps
module retry_tx_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, start = 1'b0, tx_ready = 1'b0;
  logic       net_valid = 1'b0, net_ok = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, busy, done, tx_valid;
  logic [7:0] tx_data;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  retry_tx #(.DEPTH(DEPTH), .DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .start(start), .busy(busy), .done(done),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .net_valid(net_valid), .net_ok(net_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit roll(input int pct);
    return int'($urandom % 100) < pct;
  endfunction

  task automatic run_msg(input int n, input int fails, input int pct, input bit poke);
    logic [7:0] msg [DEPTH];
    logic [7:0] prev_d;
    bit         prev_stall;
    int         idx;
    int         guard;
    int         pause;
    for (int i = 0; i < n; i++) begin
      msg[i]   = 8'($urandom);
      wr_valid = 1'b1;
      wr_data  = msg[i];
      chk(wr_ready == 1'b1, "R2 wr_ready while filling", int'(wr_ready), 1);
      @(negedge clk);
      wr_valid = 1'b0;
      if (roll(30)) @(negedge clk);
    end
    if (n == DEPTH) begin
      chk(wr_ready == 1'b0, "R2 wr_ready when full", int'(wr_ready), 0);
      wr_valid = 1'b1;
      wr_data  = 8'hA5;
      @(negedge clk);
      wr_valid = 1'b0;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
    chk(tx_valid == 1'b1, "R3 tx_valid after start", int'(tx_valid), 1);
    chk(wr_ready == 1'b0, "R2 wr_ready while busy", int'(wr_ready), 0);
    for (int att = 0; att <= fails; att++) begin
      idx = 0;
      guard = 0;
      prev_stall = 1'b0;
      prev_d = '0;
      while (idx < n && guard < 2000) begin
        guard++;
        tx_ready = roll(pct);
        if (poke) begin
          net_valid = roll(40);
          net_ok    = roll(50);
          start     = roll(20);
          wr_valid  = roll(20);
        end
        if (prev_stall)
          chk(tx_valid && tx_data == prev_d, "R5 hold under stall", int'(tx_data), int'(prev_d));
        chk(tx_valid == 1'b1, "R6 tx_valid during attempt", int'(tx_valid), 1);
        if (tx_valid && tx_ready) begin
          if (att == 0)
            chk(tx_data == msg[idx], "R5 byte order", int'(tx_data), int'(msg[idx]));
          else
            chk(tx_data == msg[idx], "R7 replayed byte", int'(tx_data), int'(msg[idx]));
          idx++;
        end
        prev_stall = tx_valid && !tx_ready;
        prev_d = tx_data;
        @(negedge clk);
      end
      net_valid = 1'b0;
      start     = 1'b0;
      wr_valid  = 1'b0;
      tx_ready  = 1'b0;
      chk(!tx_valid && busy, "R6 waiting for verdict", int'(tx_valid), 0);
      pause = int'($urandom % 4);
      for (int p = 0; p < pause; p++) begin
        @(negedge clk);
        chk(!tx_valid && busy && !done, "R6 wait holds", int'(tx_valid), 0);
      end
      net_valid = 1'b1;
      net_ok    = (att == fails);
      @(negedge clk);
      net_valid = 1'b0;
      if (att < fails) begin
        chk(tx_valid == 1'b1, "R7 replay starts next cycle", int'(tx_valid), 1);
        chk(done == 1'b0, "R7 no done on failure", int'(done), 0);
      end else begin
        chk(done == 1'b1, "R8 done pulse", int'(done), 1);
        chk(!busy && wr_ready, "R8 idle and empty", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
      end
    end
  endtask

  task automatic empty_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0 && tx_valid == 1'b0, "R4 empty start ignored", int'(busy), 0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !tx_valid && !done && wr_ready, "R1 reset state", int'(busy), 0);
    empty_start();
    run_msg(1, 0, 100, 1'b0);
    empty_start();
    run_msg(DEPTH, 3, 100, 1'b0);
    run_msg(DEPTH, 2, 40, 1'b1);
    run_msg(2, 5, 60, 1'b0);
    for (int k = 0; k < 25; k++) begin
      run_msg(1 + int'($urandom % DEPTH), int'($urandom % 5),
              30 + int'($urandom % 71), roll(50));
      if (roll(25)) empty_start();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule